// File: doc/BRIEF.md
# Serial-Input Latched LED Sink Controller

This block is the digital control core of a sixteen-channel constant-current LED sink driver. Serial data arrives one bit per serial clock pulse. The pulse is given as `shift_en`, which is sampled on the rising edge of the block clock. The bits move through a sixteen-stage shift register. The last stage drives a cascade output, so several controllers can be chained. A bank of holding latches is transparent while the latch-enable input is high and keeps its value while that input is low. The latch contents drive sixteen channel-enable outputs, which stand in for the current sinks.

An active-low output enable blanks every channel. Two status flags, undervoltage and overtemperature, also blank the channels. Each flag first passes through a two-flop synchroniser. While undervoltage is seen, the stored data is wiped. Overtemperature blanks the channels but leaves the shift register and the latches working, so the pattern comes back as soon as the flag drops. A separate `out_valid` output tells a channel that is off apart from an output stage that is disabled.

Top module: `led_sink_ctrl`

## Requirements
- R1: On a rising clock edge with `shift_en` high, stage 0 takes `sdi` and each stage k takes the old value of stage k-1. With `shift_en` low the shift register keeps its value.
- R2: `sdo` always equals stage 15 of the shift register. After sixteen shifts of a word, `sdo` shows the first bit of that word.
- R3: While `le` is high, the latches follow the shift register, including a shift made in the same cycle. While `le` is low, the latches hold their value whatever is shifted.
- R4: With `oe_n` high, `out_valid` is 0 and `chan_on` is all zeros. With `oe_n` low and no fault seen, `out_valid` is 1 and `chan_on[i]` equals latch bit i.
- R5: After reset the shift register, the latches, `sdo` and `chan_on` are all zero.
- R6: While the synchronised undervoltage flag is high, the outputs are off and the next clock edge clears the shift register and the latches; `sdi` has no effect. When the flag clears, the outputs resume with all-zero data.
- R7: While the synchronised overtemperature flag is high, the outputs are off, but shifting and latching go on. When the flag clears, the outputs show the latched data with no reset.
- R8: After sixteen shifts and a latch, the first bit shifted in drives channel 15 and the last bit drives channel 0. The word is sent MSB first, so `chan_on` equals the word.
- R9: A change on `uv_flag` or `ot_flag` reaches the outputs only after the second rising clock edge following the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Serial clock pulse, shift on this edge |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Latch enable, transparent when high |
| oe_n | input | 1 | Output enable, active low |
| uv_flag | input | 1 | Undervoltage status, asynchronous |
| ot_flag | input | 1 | Overtemperature status, asynchronous |
| sdo | output | 1 | Cascade serial data out (stage 15) |
| chan_on | output | 16 | Channel sink enables |
| out_valid | output | 1 | 1 when the output stage is enabled, 0 when high impedance |

## Verification
A shift and a latch load can fall in the same cycle: the bench holds `le` high while it shifts a word, and after each pulse it compares `chan_on` with a bench model of the shift register, which must already include the new bit. A fault flag can also arrive while data is being loaded: the bench shifts and latches a fresh word while overtemperature is seen. It checks that the channels stay dark, and that the new word appears once the flag has passed back through the synchroniser. For undervoltage it shifts ones while the flag is seen and expects all-zero data and a zero `sdo` after recovery.

// File: rtl/led_sink_pkg.sv
package led_sink_pkg;
    localparam int unsigned LED_CH_DEFAULT   = 16;
    localparam int unsigned LED_SYNC_DEFAULT = 2;

    typedef struct packed {
        logic uv;
        logic ot;
    } fault_t;

    localparam int unsigned FAULT_W = $bits(fault_t);
endpackage

// File: rtl/led_flag_sync.sv
module led_flag_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/led_shift_latch.sv
module led_shift_latch #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         sdi,
    input  logic         le,
    input  logic         wipe,
    output logic [N-1:0] shift_q,
    output logic [N-1:0] latch_q,
    output logic [N-1:0] view
);
    typedef struct packed {
        logic [N-1:0] sr;
        logic [N-1:0] lt;
    } core_t;

    core_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        if (shift_en) core_d.sr = {core_q.sr[N-2:0], sdi};
        if (le)       core_d.lt = core_d.sr;
        if (wipe)     core_d    = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign shift_q = core_q.sr;
    assign latch_q = core_q.lt;
    assign view    = le ? core_q.sr : core_q.lt;
endmodule

// File: rtl/led_out_gate.sv
module led_out_gate #(
    parameter int unsigned N = 16
) (
    input  logic         enable,
    input  logic [N-1:0] bits_in,
    output logic [N-1:0] chan_on
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        assign chan_on[i] = enable & bits_in[i];
    end
endmodule

// File: rtl/led_sink_ctrl.sv
module led_sink_ctrl
    import led_sink_pkg::*;
#(
    parameter int unsigned NUM_CH      = LED_CH_DEFAULT,
    parameter int unsigned SYNC_STAGES = LED_SYNC_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              sdi,
    input  logic              le,
    input  logic              oe_n,
    input  logic              uv_flag,
    input  logic              ot_flag,
    output logic              sdo,
    output logic [NUM_CH-1:0] chan_on,
    output logic              out_valid
);
    fault_t            flags_raw, flags_s;
    logic              uv_sync, ot_sync;
    logic [NUM_CH-1:0] shift_w, latch_w, view_w;

    assign flags_raw.uv = uv_flag;
    assign flags_raw.ot = ot_flag;

    led_flag_sync #(.WIDTH(FAULT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (flags_raw),
        .dout (flags_s)
    );

    assign uv_sync = flags_s.uv;
    assign ot_sync = flags_s.ot;

    led_shift_latch #(.N(NUM_CH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .sdi     (sdi),
        .le      (le),
        .wipe    (uv_sync),
        .shift_q (shift_w),
        .latch_q (latch_w),
        .view    (view_w)
    );

    assign out_valid = !oe_n && !uv_sync && !ot_sync;
    assign sdo       = shift_w[NUM_CH-1];

    led_out_gate #(.N(NUM_CH)) u_gate (
        .enable (out_valid),
        .bits_in(view_w),
        .chan_on(chan_on)
    );
endmodule

// File: rtl/led_sink_ctrl_chk.sv
module led_sink_ctrl_chk #(
    parameter int unsigned N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         shift_en,
    input logic         sdi,
    input logic         le,
    input logic         oe_n,
    input logic         ot_flag,
    input logic         sdo,
    input logic [N-1:0] chan_on,
    input logic         out_valid,
    input logic [N-1:0] shift_w,
    input logic [N-1:0] latch_w,
    input logic         uv_sync,
    input logic         ot_sync
);
    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !uv_sync) |=> shift_w == {$past(shift_w[N-2:0]), $past(sdi)}); // R1
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !uv_sync) |=> $stable(shift_w)); // R1
    AST_SDO_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !uv_sync) |=> sdo == $past(shift_w[N-2])); // R2
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !uv_sync) |=> $stable(latch_w)); // R3
    AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (le && !uv_sync) |=> latch_w == shift_w); // R3
    AST_OE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!out_valid && chan_on == '0)); // R4
    AST_UV_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
        uv_sync |=> (shift_w == '0 && latch_w == '0)); // R6
    AST_UV_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        uv_sync |-> (!out_valid && chan_on == '0)); // R6
    AST_OT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        ot_sync |-> (!out_valid && chan_on == '0)); // R7
    AST_OT_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ot_sync) |-> $past(ot_flag)); // R9
endmodule

bind led_sink_ctrl led_sink_ctrl_chk #(.N(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .sdi      (sdi),
    .le       (le),
    .oe_n     (oe_n),
    .ot_flag  (ot_flag),
    .sdo      (sdo),
    .chan_on  (chan_on),
    .out_valid(out_valid),
    .shift_w  (shift_w),
    .latch_w  (latch_w),
    .uv_sync  (uv_sync),
    .ot_sync  (ot_sync)
);

// File: tb/led_sink_ctrl_bench.sv
`timescale 1ns/1ps
module led_sink_ctrl_bench;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n, shift_en, sdi, le, oe_n, uv_flag, ot_flag;
    logic         sdo, out_valid;
    logic [N-1:0] chan_on;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [N-1:0] exp_sr = '0;
    logic [N-1:0] exp_lt = '0;

    always #2.5 clk = ~clk;

    led_sink_ctrl u_led_sink_ctrl (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .sdi(sdi), .le(le),
        .oe_n(oe_n), .uv_flag(uv_flag), .ot_flag(ot_flag),
        .sdo(sdo), .chan_on(chan_on), .out_valid(out_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        sdi = b;
        shift_en = 1'b1;
        tick();
        shift_en = 1'b0;
        exp_sr = {exp_sr[N-2:0], b};
        if (le) exp_lt = exp_sr;
    endtask

    task automatic load_word(input logic [N-1:0] w);
        for (int i = N - 1; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic latch_pulse();
        le = 1'b1;
        tick();
        le = 1'b0;
        exp_lt = exp_sr;
    endtask

    task automatic run_pattern(input logic [N-1:0] p);
        load_word(p);
        chk("R3 hold while le low", chan_on, exp_lt);
        chk("R2 sdo after 16 shifts", sdo, p[N-1]);
        latch_pulse();
        chk("R8 bit order on channels", chan_on, p);
        chk("R4 valid with oe_n low", out_valid, 1'b1);
        shift_bit(1'b0);
        chk("R1 one more shift on sdo", sdo, p[N-2]);
        chk("R3 latch unchanged by shift", chan_on, p);
    endtask

    initial begin
        rst_n = 1'b0; shift_en = 1'b0; sdi = 1'b0; le = 1'b0;
        oe_n = 1'b1; uv_flag = 1'b0; ot_flag = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R5 reset sdo", sdo, 1'b0);
        chk("R4 oe_n high blanks", {out_valid, chan_on}, '0);
        oe_n = 1'b0;
        tick();
        chk("R5 reset latch zero", chan_on, '0);

        for (int i = 0; i < N; i++) run_pattern(N'(1) << i);
        for (int i = 0; i < N; i++) run_pattern(~(N'(1) << i));
        run_pattern(16'hA5C3);
        run_pattern(16'hFFFF);
        run_pattern(16'h0000);
        run_pattern(16'h6E19);

        oe_n = 1'b1;
        tick();
        chk("R4 oe_n high blanks data", {out_valid, chan_on}, '0);
        oe_n = 1'b0;
        tick();
        chk("R4 oe_n low restores", chan_on, 16'h6E19);

        le = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            shift_bit(i[0] ^ i[2]);
            chk("R3 transparent during shift", chan_on, exp_sr);
        end
        le = 1'b0;
        tick();
        chk("R3 hold after le drop", chan_on, exp_sr);

        load_word(16'h1234);
        latch_pulse();
        ot_flag = 1'b1;
        tick();
        chk("R9 ot not yet seen", out_valid, 1'b1);
        tick();
        chk("R7 ot blanks", {out_valid, chan_on}, '0);
        load_word(16'hBEEF);
        latch_pulse();
        chk("R7 shifting active in ot", sdo, 1'b1);
        chk("R7 still blanked", {out_valid, chan_on}, '0);
        ot_flag = 1'b0;
        tick();
        chk("R9 ot clear lag", out_valid, 1'b0);
        tick();
        chk("R7 data kept after ot", chan_on, 16'hBEEF);

        uv_flag = 1'b1;
        tick();
        chk("R9 uv not yet seen", chan_on, 16'hBEEF);
        tick();
        chk("R6 uv blanks", {out_valid, chan_on}, '0);
        for (int i = 0; i < 4; i++) shift_bit(1'b1);
        le = 1'b1;
        tick();
        le = 1'b0;
        chk("R6 uv sdo cleared", sdo, 1'b0);
        uv_flag = 1'b0;
        tick();
        tick();
        chk("R6 outputs resume", out_valid, 1'b1);
        chk("R6 latch cleared", chan_on, '0);
        exp_sr = '0;
        exp_lt = '0;
        le = 1'b1;
        tick();
        le = 1'b0;
        chk("R6 shift register cleared", chan_on, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule